// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block decides which of several interrupt request lines is serviced next, and when. Each line has an 8-bit priority register. A lower number means a more urgent line. A 3-bit grouping setting splits every priority byte into an upper group part and a lower subpriority part. Only the group part decides whether a waiting line may interrupt the handler that is running. The subpriority only breaks ties between lines that share a group.

The block holds a pending bit and an active bit for each line, plus a small nesting stack. Each stack entry records a line that was entered and the group level it ran at.

The winning line is offered on a valid/ready handshake:
- `preempt_valid` is high while the best pending line may enter, either over the running handler or from idle.
- The handler side accepts the line by raising `preempt_ready`.
- `preempt_valid` does not depend on `preempt_ready`. Holding `preempt_ready` low stalls the offer with no loss, because the pending state stays.

When the running handler finishes, `done_i` is strobed for one cycle. In that same cycle the block reports one of two outcomes:
- `chain_valid`: the best waiting line is handed over directly, a tail-chain.
- `ret_valid`: the handler falls back to the level beneath it.

Top module: `irq_group_arb`

## Requirements
- R1: With grouping value g, a line's group value is its priority shifted right by g+1 bits, and its subpriority is the low g+1 bits. With g=7 every line has group value 0. The idle level is reported as 256 (9 bits), which is less urgent than any group.
- R2: `preempt_valid` is high only when the best eligible pending line has a group value strictly lower than `act_group`. An equal group never preempts, whatever the subpriority.
- R3: With grouping value 7, `preempt_valid` stays low whenever at least one handler is active.
- R4: Among eligible pending lines, the lowest group value wins. Ties go to the lowest subpriority, then to the lowest line index. `win_idx` carries the winner.
- R5: A one-cycle pulse on `irq_req[i]` or `sw_pend[i]` sets line i pending. Acceptance through entry or tail-chain clears it. A line that is active is never selected, even while it is pending.
- R6: In a cycle with `preempt_valid`, `preempt_ready` high and `done_i` low, the winner becomes active. `depth` then rises by one and `act_group` becomes the winner's group value. `preempt_valid` is low while `done_i` is high.
- R7: When `done_i` is high with depth > 0, and the best eligible pending line's group value is lower than the level beneath the finishing handler, `chain_valid` is high with `win_idx` naming that line. `depth` is unchanged. The level beneath is 256 at depth 1.
- R8: Otherwise, a `done_i` with depth > 0 gives `ret_valid`. `depth` falls by one and `act_group` returns to the level that was saved beneath.
- R9: `grouping` is updated from `grp_val` only when `grp_we` is high and `grp_key` equals 16'hFA05. Any other write leaves it unchanged.
- R10: At depth NEST_DEPTH, `preempt_valid` stays low. A `done_i` at depth 0 has no effect.
- R11: After reset, nothing is pending or active, `depth` is 0, `act_group` is 256, all priorities are 0 and grouping is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_LINES | Request pulses, one bit per line |
| sw_pend | input | NUM_LINES | Software pending-set pulses |
| prio_we | input | 1 | Priority write enable |
| prio_idx | input | IW | Line addressed by the priority write |
| prio_val | input | 8 | Priority value written |
| grp_we | input | 1 | Grouping write enable |
| grp_key | input | 16 | Key that must accompany a grouping write |
| grp_val | input | 3 | Grouping value written |
| preempt_valid | output | 1 | Winner may enter now |
| preempt_ready | input | 1 | Handler side accepts the offered line |
| win_idx | output | IW | Winning line index (entry or tail-chain) |
| done_i | input | 1 | Running handler has completed |
| chain_valid | output | 1 | Tail-chain to `win_idx` this cycle |
| ret_valid | output | 1 | Return to the level beneath this cycle |
| act_group | output | 9 | Group level currently executing (256 = idle) |
| depth | output | DW | Number of nested active handlers |

## Verification
The bound checker watches the stack on every cycle:
- an accepted entry grows `depth` by one;
- a tail-chain leaves `depth` alone;
- a return shrinks `depth` by one;
- entry, chain and return never coincide;
- a full stack and grouping 7 both block preemption;
- keyless grouping writes leave the setting untouched.

Some behaviour only the bench scenarios can show:
- the preempt decision across the whole grouping range and a grid of priority pairs;
- the arbitration order for ties;
- `act_group` returning to the right level at each unwind;
- a return taking precedence over a pending line that is less urgent than the interrupted level;
- an active line refusing reselection.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 8;
  localparam int GRP_W  = PRIO_W + 1;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [GRP_W-1:0]  grp_t;
  localparam grp_t IDLE_LVL = grp_t'(9'h100);

  // group value: priority with the low g+1 bits dropped
  function automatic grp_t group_of(prio_t p, logic [2:0] g);
    logic [3:0] sh;
    sh = {1'b0, g} + 4'd1;
    return grp_t'({1'b0, p} >> sh);
  endfunction

  // subpriority: the low g+1 bits of the priority
  function automatic prio_t sub_of(prio_t p, logic [2:0] g);
    return p & (8'hFF >> (3'd7 - g));
  endfunction
endpackage

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        idx,
  input  prio_t                val,
  input  logic [2:0]           grouping,
  output grp_t  [NUM_LINES-1:0] grp,
  output prio_t [NUM_LINES-1:0] sub
);
  prio_t [NUM_LINES-1:0] prio_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       prio_q[i] <= '0;
      else if (we && idx == IW'(i))     prio_q[i] <= val;
    end
    assign grp[i] = group_of(prio_q[i], grouping);
    assign sub[i] = sub_of(prio_q[i], grouping);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0]  elig,
  input  grp_t  [NUM_LINES-1:0] grp,
  input  prio_t [NUM_LINES-1:0] sub,
  output logic                  found,
  output logic [IW-1:0]         idx,
  output grp_t                  best_grp
);
  prio_t best_sub;

  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_grp = IDLE_LVL;
    best_sub = '1;
    // strict comparisons keep the lowest index on full ties
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elig[i] && (!found || grp[i] < best_grp ||
                      (grp[i] == best_grp && sub[i] < best_sub))) begin
        found    = 1'b1;
        idx      = IW'(i);
        best_grp = grp[i];
        best_sub = sub[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = 3,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          repl,
  input  logic          pop,
  input  logic [IW-1:0] in_idx,
  input  grp_t          in_grp,
  output logic [DW-1:0] cnt,
  output logic          full,
  output logic          empty,
  output logic [IW-1:0] top_idx,
  output grp_t          top_grp,
  output grp_t          below_grp
);
  logic [DW-1:0]            cnt_q;
  grp_t [DEPTH-1:0]         grp_q;
  logic [DEPTH-1:0][IW-1:0] idx_q;
  logic [PW-1:0]            top_ptr, below_ptr, push_ptr;

  assign top_ptr   = PW'(cnt_q - DW'(1));
  assign below_ptr = PW'(cnt_q - DW'(2));
  assign push_ptr  = PW'(cnt_q);
  assign cnt       = cnt_q;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == DW'(DEPTH));
  assign top_idx   = empty ? '0 : idx_q[top_ptr];
  assign top_grp   = empty ? IDLE_LVL : grp_q[top_ptr];
  assign below_grp = (cnt_q < DW'(2)) ? IDLE_LVL : grp_q[below_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        grp_q[i] <= IDLE_LVL;
        idx_q[i] <= '0;
      end
    end else if (push && !full) begin
      grp_q[push_ptr] <= in_grp;
      idx_q[push_ptr] <= in_idx;
      cnt_q           <= cnt_q + DW'(1);
    end else if (repl && !empty) begin
      grp_q[top_ptr] <= in_grp;
      idx_q[top_ptr] <= in_idx;
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - DW'(1);
    end
  end
endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb
  import irq_arb_pkg::*;
#(
  parameter int          NUM_LINES  = 8,
  parameter int          NEST_DEPTH = 4,
  parameter logic [15:0] GRP_KEY    = 16'hFA05,
  localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int DW = $clog2(NEST_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic [NUM_LINES-1:0] sw_pend,
  input  logic                 prio_we,
  input  logic [IW-1:0]        prio_idx,
  input  logic [7:0]           prio_val,
  input  logic                 grp_we,
  input  logic [15:0]          grp_key,
  input  logic [2:0]           grp_val,
  output logic                 preempt_valid,
  input  logic                 preempt_ready,
  output logic [IW-1:0]        win_idx,
  input  logic                 done_i,
  output logic                 chain_valid,
  output logic                 ret_valid,
  output logic [8:0]           act_group,
  output logic [DW-1:0]        depth
);
  logic [2:0]            grouping_q;
  logic [NUM_LINES-1:0]  pend_q, act_q, elig, accept_vec, finish_vec;
  grp_t  [NUM_LINES-1:0] line_grp;
  prio_t [NUM_LINES-1:0] line_sub;
  logic                  found, st_full, st_empty, take;
  grp_t                  win_grp, top_grp, below_grp;
  logic [IW-1:0]         top_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          grouping_q <= '0;
    else if (grp_we && grp_key == GRP_KEY) grouping_q <= grp_val;
  end

  irq_prio_bank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(prio_we), .idx(prio_idx), .val(prio_val),
    .grouping(grouping_q), .grp(line_grp), .sub(line_sub)
  );

  assign elig = pend_q & ~act_q;

  irq_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .elig(elig), .grp(line_grp), .sub(line_sub),
    .found(found), .idx(win_idx), .best_grp(win_grp)
  );

  assign preempt_valid = found && !done_i && !st_full && (win_grp < top_grp);
  assign take          = preempt_valid && preempt_ready;
  assign chain_valid   = done_i && !st_empty && found && (win_grp < below_grp);
  assign ret_valid     = done_i && !st_empty && !chain_valid;

  irq_nest_stack #(.DEPTH(NEST_DEPTH), .IW(IW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(take), .repl(chain_valid), .pop(ret_valid),
    .in_idx(win_idx), .in_grp(win_grp), .cnt(depth), .full(st_full),
    .empty(st_empty), .top_idx(top_idx), .top_grp(top_grp), .below_grp(below_grp)
  );

  assign act_group = top_grp;

  always_comb begin
    accept_vec = '0;
    finish_vec = '0;
    if (take || chain_valid)     accept_vec[win_idx] = 1'b1;
    if (chain_valid || ret_valid) finish_vec[top_idx] = 1'b1;
  end

  // a set arriving with acceptance of the same line wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~accept_vec) | irq_req | sw_pend;
      act_q  <= (act_q & ~finish_vec) | accept_vec;
    end
  end
endmodule

// File: rtl/irq_group_arb_chk.sv
module irq_group_arb_chk #(
  parameter int          NEST_DEPTH = 4,
  parameter logic [15:0] GRP_KEY    = 16'hFA05,
  localparam int DW = $clog2(NEST_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          preempt_valid,
  input logic          preempt_ready,
  input logic          done_i,
  input logic          chain_valid,
  input logic          ret_valid,
  input logic [8:0]    act_group,
  input logic [DW-1:0] depth,
  input logic          grp_we,
  input logic [15:0]   grp_key,
  input logic [2:0]    grouping_q
);
  a_r6_entry_push: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_valid && preempt_ready) |=> depth == DW'($past(depth) + DW'(1)));

  a_r6_no_offer_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> !preempt_valid);

  a_r7_chain_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    chain_valid |=> depth == $past(depth));

  a_r8_ret_pops: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> depth == DW'($past(depth) - DW'(1)));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chain_valid, ret_valid, preempt_valid && preempt_ready}));

  a_r3_no_preempt_g7: assert property (@(posedge clk) disable iff (!rst_n)
    (grouping_q == 3'd7 && depth != '0) |-> !preempt_valid);

  a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == DW'(NEST_DEPTH)) |-> !preempt_valid);

  a_r10_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> (!chain_valid && !ret_valid && act_group == 9'h100));

  a_r9_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_we && grp_key != GRP_KEY) |=> $stable(grouping_q));
endmodule

bind irq_group_arb irq_group_arb_chk #(.NEST_DEPTH(NEST_DEPTH), .GRP_KEY(GRP_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .preempt_valid(preempt_valid), .preempt_ready(preempt_ready),
  .done_i(done_i), .chain_valid(chain_valid), .ret_valid(ret_valid),
  .act_group(act_group), .depth(depth), .grp_we(grp_we), .grp_key(grp_key),
  .grouping_q(grouping_q)
);

// File: tb/irq_group_arb_bench.sv
module irq_group_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int ND = 4;
  localparam int IW = 3;
  localparam int DW = 3;
  localparam logic [15:0] KEY = 16'hFA05;

  logic clk = 0, rst_n = 0;
  logic [NL-1:0] irq_req = '0, sw_pend = '0;
  logic prio_we = 0, grp_we = 0, preempt_ready = 0, done_i = 0;
  logic [IW-1:0] prio_idx = '0;
  logic [7:0] prio_val = '0;
  logic [15:0] grp_key = '0;
  logic [2:0] grp_val = '0;
  logic preempt_valid, chain_valid, ret_valid;
  logic [IW-1:0] win_idx;
  logic [8:0] act_group;
  logic [DW-1:0] depth;
  int n_chk = 0, n_fail = 0, cyc_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_group_arb #(.NUM_LINES(NL), .NEST_DEPTH(ND), .GRP_KEY(KEY)) u_irq_group_arb (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_pend(sw_pend),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_val(prio_val),
    .grp_we(grp_we), .grp_key(grp_key), .grp_val(grp_val),
    .preempt_valid(preempt_valid), .preempt_ready(preempt_ready), .win_idx(win_idx),
    .done_i(done_i), .chain_valid(chain_valid), .ret_valid(ret_valid),
    .act_group(act_group), .depth(depth)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
      finish_run();
    end
  end

  task automatic wr_prio(input int i, input int v);
    @(negedge clk); prio_we = 1; prio_idx = IW'(i); prio_val = 8'(v);
    @(negedge clk); prio_we = 0;
  endtask

  task automatic wr_grp(input int g, input logic [15:0] k);
    @(negedge clk); grp_we = 1; grp_val = 3'(g); grp_key = k;
    @(negedge clk); grp_we = 0; grp_key = '0;
  endtask

  task automatic req(input int i, input bit sw);
    @(negedge clk);
    if (sw) sw_pend[i] = 1'b1; else irq_req[i] = 1'b1;
    @(negedge clk); sw_pend = '0; irq_req = '0; #1;
  endtask

  task automatic accept();
    @(negedge clk); preempt_ready = 1;
    @(negedge clk); preempt_ready = 0; #1;
  endtask

  // raise done, sample the same-cycle outcome, then drop it
  task automatic finish_h(output bit ch, output bit rt, output int ix);
    @(negedge clk); done_i = 1; #1;
    ch = chain_valid; rt = ret_valid; ix = int'(win_idx);
    @(negedge clk); done_i = 0; #1;
  endtask

  function automatic int grp_of(input int p, input int g);
    return p >> (g + 1);
  endfunction

  initial begin
    bit ch, rt;
    int ix;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R11 reset state
    chk(depth == 0, "R11 depth", int'(depth), 0);
    chk(act_group == 256, "R11 act_group", int'(act_group), 256);
    chk(!preempt_valid, "R11 preempt_valid", int'(preempt_valid), 0);

    // R10 done at depth 0 has no effect
    @(negedge clk); done_i = 1; #1;
    chk(!chain_valid && !ret_valid, "R10 idle done", int'({chain_valid, ret_valid}), 0);
    @(negedge clk); done_i = 0; #1;
    chk(depth == 0, "R10 idle done depth", int'(depth), 0);

    // R1 R2 R3 R7: sweep grouping and priority pairs
    for (int g = 0; g < 8; g++) begin
      wr_grp(g, KEY);
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int p0, p1;
          bit exp_pre;
          p0 = a * 17; p1 = b * 17;
          wr_prio(0, p0); wr_prio(1, p1);
          req(0, 0); accept();
          req(1, 0);
          exp_pre = grp_of(p1, g) < grp_of(p0, g);
          chk(preempt_valid == exp_pre, "R2 R1 R3 preempt sweep", int'(preempt_valid), int'(exp_pre));
          finish_h(ch, rt, ix);
          chk(ch && ix == 1, "R7 chain from depth 1", ix, 1);
          finish_h(ch, rt, ix);
        end
      end
    end

    // R4 arbitration order at g=3
    wr_grp(3, KEY);
    wr_prio(0, 8'h50); wr_prio(1, 8'h34); wr_prio(2, 8'h31);
    wr_prio(3, 8'h31); wr_prio(4, 8'h40);
    for (int i = 0; i < 5; i++) req(i, 1);
    chk(preempt_valid && win_idx == 2, "R4 group then sub then index", int'(win_idx), 2);
    accept();
    chk(act_group == 3, "R6 act_group after entry", int'(act_group), 3);
    chk(!preempt_valid, "R2 equal group no preempt", int'(preempt_valid), 0);
    finish_h(ch, rt, ix); chk(ch && ix == 3, "R4 index tie chain", ix, 3);
    finish_h(ch, rt, ix); chk(ch && ix == 1, "R4 sub order chain", ix, 1);
    finish_h(ch, rt, ix); chk(ch && ix == 4, "R4 group order chain", ix, 4);
    finish_h(ch, rt, ix); chk(ch && ix == 0, "R4 last chain", ix, 0);
    finish_h(ch, rt, ix); chk(rt && !ch, "R8 return to idle", int'(rt), 1);
    chk(depth == 0 && act_group == 256, "R8 idle restored", int'(act_group), 256);

    // R9 keyless write ignored: stays at g=0
    wr_grp(0, KEY);
    wr_grp(3, 16'h1234);
    wr_prio(0, 8'h10); wr_prio(1, 8'h18);
    req(1, 0); accept();
    req(0, 0);
    chk(preempt_valid && win_idx == 0, "R9 keyless grouping ignored", int'(preempt_valid), 1);
    finish_h(ch, rt, ix); finish_h(ch, rt, ix);

    // R10 R8 nesting to full depth, g=0
    for (int i = 0; i < 5; i++) wr_prio(i, 8'h80 - 8'h10 * i);
    for (int i = 0; i < 4; i++) begin req(i, 0); accept(); end
    chk(depth == 4 && act_group == 40, "R6 nested act_group", int'(act_group), 40);
    req(4, 0);
    chk(!preempt_valid, "R10 full stack blocks", int'(preempt_valid), 0);
    finish_h(ch, rt, ix); chk(ch && ix == 4, "R7 chain beats beneath level", ix, 4);
    chk(depth == 4, "R7 depth kept", int'(depth), 4);
    finish_h(ch, rt, ix); chk(rt, "R8 return at depth 4", int'(rt), 1);
    chk(depth == 3 && act_group == 48, "R8 level restored", int'(act_group), 48);
    finish_h(ch, rt, ix); chk(act_group == 56, "R8 level restored 2", int'(act_group), 56);
    finish_h(ch, rt, ix); chk(act_group == 64, "R8 level restored 3", int'(act_group), 64);
    finish_h(ch, rt, ix); chk(act_group == 256 && depth == 0, "R8 unwound", int'(act_group), 256);

    // R8 return preferred over a line less urgent than the level beneath
    wr_prio(0, 8'h40); wr_prio(1, 8'h10); wr_prio(2, 8'h60);
    req(0, 0); accept(); req(1, 0); accept(); req(2, 0);
    finish_h(ch, rt, ix); chk(rt && !ch, "R8 return over low pending", int'(rt), 1);
    chk(act_group == 32, "R8 restored to interrupted group", int'(act_group), 32);
    finish_h(ch, rt, ix); chk(ch && ix == 2, "R7 chain after unwind", ix, 2);
    finish_h(ch, rt, ix);

    // R5 an active line is not reselected
    req(0, 0); accept();
    req(0, 1);
    chk(!preempt_valid, "R5 active line not offered", int'(preempt_valid), 0);
    finish_h(ch, rt, ix); chk(rt && !ch, "R5 active line not chained", int'(ch), 0);
    chk(preempt_valid && win_idx == 0, "R5 pending kept after finish", int'(preempt_valid), 1);
    accept(); finish_h(ch, rt, ix);

    // R3 grouping 7: most urgent line still waits
    wr_grp(7, KEY);
    wr_prio(0, 8'hFF); wr_prio(1, 8'h00);
    req(0, 0); accept(); req(1, 0);
    chk(!preempt_valid, "R3 no preemption at g7", int'(preempt_valid), 0);
    finish_h(ch, rt, ix); chk(ch && ix == 1, "R3 handed over by chain", ix, 1);
    finish_h(ch, rt, ix);

    finish_run();
  end
endmodule